// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block turns a digitized supply monitor into the control states of a battery-backed memory system. It receives three asynchronous levels: supply above its trip point, supply above the battery voltage, and battery present. It also receives a periodic time tick, nominally one per millisecond. From these it produces four things: a processor reset enable for an open-drain driver, a power-fail flag, a recovery-done flag that ends write protection, and a select that switches the memory supply over to the battery.

All three levels pass through a multi-flop synchronizer. A saturating tick counter runs while the synchronized supply is good and clears whenever it is not. The recovery interval ends after `REC_TICKS` ticks. The processor reset is released after `RST_TICKS` ticks. `REC_TICKS` must be smaller than `RST_TICKS`, so write protection always ends before the processor leaves reset. The defaults are 125 and 200 ticks.

A freshness seal keeps the battery disconnected after it is attached to an unpowered system. The seal lifts the first time the supply rises above its trip point.

Top module: `pf_supervisor`

## Requirements
- R1: While `rst_ni` is low and right after it goes high, the outputs are at their reset values: `sys_rst_no`=0 (reset driven), `pwr_fail_o`=1, `recov_done_o`=0, `bat_sel_o`=0 and `seal_o`=1.
- R2: When `sup_ok_i` goes low, by the third rising clock edge `sys_rst_no`=0, `pwr_fail_o`=1 and `recov_done_o`=0.
- R3: `recov_done_o` goes high on the clock edge after the edge at which the `REC_TICKS`-th tick is counted.
  - A tick is counted when `tick_i`=1 at a rising edge while the synchronized supply is good. Synchronization takes two edges after `sup_ok_i` rises.
  - Before that edge, `recov_done_o`=0.
- R4: `sys_rst_no` goes high one edge after the `RST_TICKS`-th counted tick. It is never high while `recov_done_o` is low.
- R5: Ticks that arrive while the supply is below trip are not counted. A power failure during the hold restarts the count from zero at the next power-good.
- R6: `bat_sel_o`=1 only when all four of these hold: the block is unsealed, `bat_in_i`=1, `sup_ok_i`=0 and `sup_gt_bat_i`=0. Otherwise it is 0. The output settles within four edges of an input change.
- R7: `seal_o` becomes 1 whenever the battery is absent (`bat_in_i`=0) while the supply is below trip. While the block is sealed, `bat_sel_o`=0.
- R8: `seal_o` clears once the synchronized supply is above trip. Removing and reattaching the battery while the supply is good leaves it clear.
- R9: Ticks after the reset release change nothing; the counter saturates at `RST_TICKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| sup_ok_i | input | 1 | Supply above trip point (asynchronous) |
| sup_gt_bat_i | input | 1 | Supply above battery voltage (asynchronous) |
| bat_in_i | input | 1 | Battery present (asynchronous) |
| sys_rst_no | output | 1 | Processor reset, active low, registered enable for an open-drain pull-down |
| pwr_fail_o | output | 1 | Supply below trip point |
| recov_done_o | output | 1 | Recovery interval over; write protection may end |
| bat_sel_o | output | 1 | Select battery as memory supply |
| seal_o | output | 1 | Freshness seal active |

## Verification
Several properties are checked by assertions on every cycle:
- reset follows a synchronized power loss one edge later;
- reset is never released ahead of recovery;
- the counter stays bounded and clears while power is down;
- a sealed block never selects the battery, and battery selection implies a power-fail state.

The bench scenarios cover what needs stimulus sequences. These are the exact tick at which recovery and release happen, the restart of the hold after a failure partway through it, and the full sweep of battery presence against the supply-versus-battery comparison. They also cover the seal being set by a battery swap while unpowered, and not being set by a swap while powered.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    PH_DOWN    = 2'd0,
    PH_PROTECT = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RUN     = 2'd3
  } phase_e;

  localparam int unsigned SIG_SUP_OK  = 0;
  localparam int unsigned SIG_GT_BAT  = 1;
  localparam int unsigned SIG_BAT_IN  = 2;
  localparam int unsigned SIG_COUNT   = 3;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pf_hold_timer.sv
module pf_hold_timer #(
  parameter int unsigned RST_TICKS = 200,
  parameter int unsigned REC_TICKS = 125,
  localparam int unsigned CNT_W    = $clog2(RST_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic rec_hit_o,
  output logic rst_hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_TICKS);
  localparam logic [CNT_W-1:0] CNT_REC = CNT_W'(REC_TICKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!run_i)                         cnt_q <= '0;
    else if (tick_i && (cnt_q != CNT_MAX))   cnt_q <= cnt_q + 1'b1;
  end

  assign rec_hit_o = (cnt_q >= CNT_REC);
  assign rst_hit_o = (cnt_q == CNT_MAX);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R9
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R5
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/pf_seal.sv
module pf_seal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_ok_i,
  input  logic bat_in_i,
  output logic seal_o
);
  logic seal_q;

  // absent cell while unpowered: next attach is treated as fresh
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     seal_q <= 1'b1;
    else if (sup_ok_i)               seal_q <= 1'b0;
    else if (!bat_in_i)              seal_q <= 1'b1;
  end

  assign seal_o = seal_q;

  AST_SEAL_LIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_ok_i |=> !seal_o); // R8
endmodule

// File: rtl/pf_supervisor.sv
module pf_supervisor
  import pf_pkg::*;
#(
  parameter int unsigned RST_TICKS   = 200,
  parameter int unsigned REC_TICKS   = 125,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sup_ok_i,
  input  logic sup_gt_bat_i,
  input  logic bat_in_i,
  output logic sys_rst_no,
  output logic pwr_fail_o,
  output logic recov_done_o,
  output logic bat_sel_o,
  output logic seal_o
);
  logic [SIG_COUNT-1:0] raw_in, sync_in;
  logic vok_s, gt_bat_s, bat_in_s;
  logic rec_hit, rst_hit;
  logic seal_q;
  phase_e phase_d, phase_q;
  logic rst_n_q, bat_sel_q;

  assign raw_in[SIG_SUP_OK] = sup_ok_i;
  assign raw_in[SIG_GT_BAT] = sup_gt_bat_i;
  assign raw_in[SIG_BAT_IN] = bat_in_i;

  pf_sync #(.WIDTH(SIG_COUNT), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign vok_s    = sync_in[SIG_SUP_OK];
  assign gt_bat_s = sync_in[SIG_GT_BAT];
  assign bat_in_s = sync_in[SIG_BAT_IN];

  pf_hold_timer #(.RST_TICKS(RST_TICKS), .REC_TICKS(REC_TICKS)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (vok_s),
    .tick_i   (tick_i),
    .rec_hit_o(rec_hit),
    .rst_hit_o(rst_hit)
  );

  pf_seal i_seal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sup_ok_i(vok_s),
    .bat_in_i(bat_in_s),
    .seal_o  (seal_q)
  );

  always_comb begin
    if (!vok_s)       phase_d = PH_DOWN;
    else if (rst_hit) phase_d = PH_RUN;
    else if (rec_hit) phase_d = PH_HOLD;
    else              phase_d = PH_PROTECT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_DOWN;
      rst_n_q   <= 1'b0;
      bat_sel_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      rst_n_q   <= (phase_d == PH_RUN);
      bat_sel_q <= !seal_q && bat_in_s && !vok_s && !gt_bat_s;
    end
  end

  assign sys_rst_no   = rst_n_q;
  assign pwr_fail_o   = (phase_q == PH_DOWN);
  assign recov_done_o = (phase_q == PH_HOLD) || (phase_q == PH_RUN);
  assign bat_sel_o    = bat_sel_q;
  assign seal_o       = seal_q;

  AST_RST_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vok_s |=> (!sys_rst_no && pwr_fail_o)); // R2
  AST_REC_BEFORE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no |-> recov_done_o); // R4
  AST_NO_SKIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PROTECT) |=> (phase_q != PH_RUN)); // R4
  AST_SEAL_NO_BAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seal_q |=> !bat_sel_o); // R7
  AST_BAT_ONLY_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_sel_o |-> pwr_fail_o); // R6
endmodule

// File: tb/test_pf_supervisor.sv
module test_pf_supervisor;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned RST_T  = 6;
  localparam int unsigned REC_T  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sup_ok = 1'b0, gt_bat = 1'b0, bat_in = 1'b1;
  logic rst_no, pfail, rdone, bsel, seal;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  pf_supervisor #(.RST_TICKS(RST_T), .REC_TICKS(REC_T)) i_pf_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sup_ok_i(sup_ok),
    .sup_gt_bat_i(gt_bat), .bat_in_i(bat_in), .sys_rst_no(rst_no),
    .pwr_fail_o(pfail), .recov_done_o(rdone), .bat_sel_o(bsel), .seal_o(seal));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one tick, then one more edge so registered outputs reflect it
  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 rst", rst_no, 1'b0); chk("R1 pfail", pfail, 1'b1);
    chk("R1 rdone", rdone, 1'b0); chk("R1 bsel", bsel, 1'b0); chk("R1 seal", seal, 1'b1);
    rst_n = 1'b1;
    cyc(6);
    // sealed, battery present, supply below trip and below battery
    chk("R7 sealed bsel", bsel, 1'b0); chk("R7 seal", seal, 1'b1);
    chk("R1 rst after", rst_no, 1'b0);

    // ticks while down ignored
    for (int i = 0; i < 10; i++) pulse_tick();
    sup_ok = 1'b1; gt_bat = 1'b1;
    cyc(3);
    chk("R5 ignored ticks rdone", rdone, 1'b0);
    chk("R8 seal lifted", seal, 1'b0);
    chk("R3 pfail up", pfail, 1'b0);
    for (int k = 1; k <= RST_T + 2; k++) begin
      pulse_tick();
      chk("R3 rdone sweep", rdone, logic'(k >= REC_T));
      chk("R4 rst sweep", rst_no, logic'(k >= RST_T));
      chk("R9 pfail", pfail, 1'b0);
    end

    // battery swap while powered keeps seal clear
    bat_in = 1'b0; cyc(6);
    chk("R8 swap seal", seal, 1'b0); chk("R6 up bsel", bsel, 1'b0);
    bat_in = 1'b1; gt_bat = 1'b0; cyc(6);
    chk("R8 reattach seal", seal, 1'b0); chk("R6 up below bat", bsel, 1'b0);

    // fail partway through hold, then restart
    sup_ok = 1'b0; gt_bat = 1'b1;
    cyc(3);
    chk("R2 rst", rst_no, 1'b0); chk("R2 pfail", pfail, 1'b1); chk("R2 rdone", rdone, 1'b0);
    sup_ok = 1'b1; cyc(3);
    for (int k = 1; k < RST_T; k++) pulse_tick();
    chk("R4 partial", rst_no, 1'b0); chk("R3 partial", rdone, 1'b1);
    sup_ok = 1'b0; cyc(3);
    chk("R2 mid hold", rst_no, 1'b0); chk("R2 mid pfail", pfail, 1'b1);
    pulse_tick();
    sup_ok = 1'b1; cyc(3);
    for (int k = 1; k < RST_T; k++) pulse_tick();
    chk("R5 restart held", rst_no, 1'b0);
    pulse_tick();
    chk("R5 restart release", rst_no, 1'b1);

    // battery select sweep while down and unsealed
    sup_ok = 1'b0;
    for (int g = 0; g < 2; g++) begin
      gt_bat = logic'(g); cyc(6);
      chk("R6 down sweep", bsel, logic'(g == 0));
    end
    gt_bat = 1'b0;
    bat_in = 1'b0; cyc(6);
    chk("R6 absent", bsel, 1'b0); chk("R7 reseal", seal, 1'b1);
    bat_in = 1'b1; cyc(6);
    chk("R7 fresh cell", bsel, 1'b0); chk("R7 still sealed", seal, 1'b1);
    sup_ok = 1'b1; cyc(6);
    chk("R8 unseal", seal, 1'b0); chk("R6 up", bsel, 1'b0);
    sup_ok = 1'b0; cyc(6);
    chk("R6 after unseal", bsel, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule